// File: doc/BRIEF.md
# Deinterleaving half-to-single vector converter

This block takes one source vector of VL bits made of packed 16-bit half-precision floating-point elements. It widens every element to 32-bit single precision and splits the widened results by element parity over two destination vectors. Even-indexed source elements fill the first destination, and odd-indexed ones fill the second. For pair index p, source element 2p becomes element p of the first result, and source element 2p+1 becomes element p of the second. VL must be a multiple of 32, which gives VL/32 pairs.

A small decode stage reads a 32-bit instruction word alongside the data. It checks the fixed opcode pattern and extracts the source register number. It also derives an adjacent even/odd pair of destination register numbers. If the word is not recognised, or if the feature enable input is low, the block raises a one-cycle undefined flag and produces no result.

The conversion is combinational. One output register stage holds both results, the register numbers and an invalid-operation flag. That stage sits behind a valid/ready handshake on each side.

Top module: `hcvt_deint`

## Requirements
- R1: Element p of `out_even` (bits 32p+31:32p) is the widened value of source element 2p (bits 32p+15:32p of `in_src`), for every p from 0 to VL/32-1.
- R2: Element p of `out_odd` is the widened value of source element 2p+1 (bits 32p+31:32p+16 of `in_src`).
- R3: `out_dst0` equals twice the 4-bit field in instruction bits 4:1, and `out_dst1` equals `out_dst0` plus one.
- R4: `out_srcreg` equals instruction bits 9:5.
- R5: A word is recognised only when bits 31:10 equal 1100000110100000111000 and bit 0 is 1. When an unrecognised word is accepted, `out_undef` is high in the next cycle and `out_valid` stays low.
- R6: When a word is accepted while `feat_en` is low, `out_undef` is high in the next cycle and no result is produced, even if the word is recognised.
- R7: A normal half value keeps its sign. Its exponent is rebiased from 15 to 127, and its 10-bit mantissa fills the top of the 23-bit fraction with zeros below (for example, 0x3C00 becomes 0x3F800000).
- R8: A half subnormal becomes the exactly equal single normal (for example, 0x0001 becomes 0x33800000). A zero keeps its sign.
- R9: A half infinity becomes a single infinity of the same sign. A quiet NaN (mantissa bit 9 set) keeps its sign and its mantissa, placed at the top of the fraction.
- R10: A signalling NaN (exponent all ones, mantissa bit 9 clear, mantissa nonzero) is quieted by setting fraction bit 22, with the rest of the payload kept. `out_invalid` is high with the result if any element of the vector was a signalling NaN, and low otherwise.
- R11: `out_valid` rises in the cycle after an accepted valid word. While `out_ready` is low, the outputs stay unchanged and `in_ready` is low. The accept condition is `in_valid && in_ready`, with `in_ready = !out_valid || out_ready`.
- R12: After reset, `out_valid` and `out_undef` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| feat_en | input | 1 | Feature implemented/enabled |
| in_valid | input | 1 | Input word and vector are valid |
| in_ready | output | 1 | Block can accept input |
| in_insn | input | 32 | Instruction word |
| in_src | input | VL | Packed half-precision source vector |
| out_valid | output | 1 | Result held in output stage |
| out_ready | input | 1 | Consumer takes the result |
| out_even | output | VL | Widened even-indexed elements |
| out_odd | output | VL | Widened odd-indexed elements |
| out_dst0 | output | 5 | First destination register number |
| out_dst1 | output | 5 | Second destination register number |
| out_srcreg | output | 5 | Source register number |
| out_invalid | output | 1 | Some element was a signalling NaN |
| out_undef | output | 1 | One-cycle undefined-instruction flag |

## Verification
The bench builds the block with VL = 64, which gives four elements per vector. With four elements per transaction, a sweep of 16384 back-to-back transactions passes every one of the 65536 half-precision encodings through the converter. Each result is compared with a reference that normalises subnormals arithmetically. The same sweep cycles through every destination field and source field value. Directed transactions then cover each special-value class, backpressure, feature disable and corrupted opcode bits.

// File: rtl/hcvt_deint.sv
module hcvt_deint #(
  parameter int VL = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          feat_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_insn,
  input  logic [VL-1:0] in_src,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VL-1:0] out_even,
  output logic [VL-1:0] out_odd,
  output logic [4:0]    out_dst0,
  output logic [4:0]    out_dst1,
  output logic [4:0]    out_srcreg,
  output logic          out_invalid,
  output logic          out_undef
);
  localparam int PAIRS = VL / 32;
  localparam logic [21:0] OPC = 22'b1100000110100000111000;

  function automatic logic [31:0] widen(input logic [15:0] h);
    logic [4:0]  e;
    logic [9:0]  m;
    logic [3:0]  k;
    logic [22:0] f;
    e = h[14:10];
    m = h[9:0];
    k = 4'd0;
    for (int i = 0; i < 10; i++)
      if (m[i]) k = 4'(i);
    f = {m, 13'b0} << (4'd10 - k);
    if (e == 5'd0)
      return (m == 10'd0) ? {h[15], 31'b0} : {h[15], 8'd103 + {4'b0, k}, f};
    else if (e == 5'h1f)
      return (m == 10'd0) ? {h[15], 8'hff, 23'b0} : {h[15], 8'hff, 1'b1, m[8:0], 13'b0};
    else
      return {h[15], {3'b0, e} + 8'd112, m, 13'b0};
  endfunction

  function automatic logic is_snan(input logic [15:0] h);
    return (h[14:10] == 5'h1f) && !h[9] && (h[8:0] != 9'd0);
  endfunction

  logic [VL-1:0]      even_n, odd_n;
  logic [2*PAIRS-1:0] snan_n;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign even_n[32*p +: 32] = widen(in_src[32*p +: 16]);
    assign odd_n[32*p +: 32]  = widen(in_src[32*p+16 +: 16]);
    assign snan_n[2*p]        = is_snan(in_src[32*p +: 16]);
    assign snan_n[2*p+1]      = is_snan(in_src[32*p+16 +: 16]);
  end

  wire take = in_valid && in_ready;
  wire recog = (in_insn[31:10] == OPC) && in_insn[0];
  wire good = recog && feat_en;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
    end else begin
      out_undef <= take && !good;
      if (take && good)
        out_valid <= 1'b1;
      else if (out_ready)
        out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take && good) begin
      out_even    <= even_n;
      out_odd     <= odd_n;
      out_dst0    <= {in_insn[4:1], 1'b0};
      out_dst1    <= {in_insn[4:1], 1'b1};
      out_srcreg  <= in_insn[9:5];
      out_invalid <= |snan_n;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_even) && $stable(out_odd) && $stable(out_dst0));
  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take && good |=> out_valid);
  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  assert_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_dst1 == out_dst0 + 5'd1) && !out_dst0[0]);
  assert_undef_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> !out_valid);
  assert_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take && !recog |=> out_undef);
endmodule

// File: tb/hcvt_deint_tb_top.sv
module hcvt_deint_tb_top;
  localparam int VL = 64;
  localparam logic [21:0] OPC = 22'b1100000110100000111000;

  logic clk = 0, rst_n = 0, feat_en = 1, in_valid = 0, out_ready = 1;
  logic [31:0] in_insn = 0;
  logic [VL-1:0] in_src = 0;
  logic in_ready, out_valid, out_invalid, out_undef;
  logic [VL-1:0] out_even, out_odd;
  logic [4:0] out_dst0, out_dst1, out_srcreg;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  hcvt_deint #(.VL(VL)) dut_i (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_src(in_src), .out_valid(out_valid), .out_ready(out_ready),
    .out_even(out_even), .out_odd(out_odd), .out_dst0(out_dst0), .out_dst1(out_dst1),
    .out_srcreg(out_srcreg), .out_invalid(out_invalid), .out_undef(out_undef));

  function automatic logic [31:0] ref_w(input logic [15:0] h);
    int ex, m;
    ex = int'(h[14:10]);
    m = int'(h[9:0]);
    if (ex == 31) begin
      if (m == 0) return {h[15], 8'hff, 23'b0};
      return {h[15], 8'hff, 1'b1, h[8:0], 13'b0};
    end
    if (ex == 0) begin
      if (m == 0) return {h[15], 31'b0};
      ex = -14;
      while (m < 1024) begin m = m * 2; ex = ex - 1; end
      return {h[15], 8'(ex + 127), 10'(m), 13'b0};
    end
    return {h[15], 8'(ex - 15 + 127), h[9:0], 13'b0};
  endfunction

  function automatic logic ref_sn(input logic [15:0] h);
    return h[14:10] == 5'h1f && h[9] == 1'b0 && h[8:0] != 0;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [4:0] zn, input logic [3:0] zd);
    return {OPC, zn, zd, 1'b1};
  endfunction

  task automatic one(input logic [31:0] insn, input logic [63:0] src,
                     input logic [63:0] e_even, input logic [63:0] e_odd,
                     input logic e_inv, input string tag);
    @(negedge clk);
    in_insn = insn; in_src = src; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " valid"}, 128'(out_valid), 128'(1));
    chk({tag, " even"}, 128'(out_even), 128'(e_even));
    chk({tag, " odd"}, 128'(out_odd), 128'(e_odd));
    chk({tag, " invalid"}, 128'(out_invalid), 128'(e_inv));
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] pe, po;
    logic [4:0] pd0, pd1, ps;
    logic pi;
    repeat (3) @(negedge clk);
    chk("R12 out_valid", 128'(out_valid), 0);
    chk("R12 out_undef", 128'(out_undef), 0);
    rst_n = 1;

    pe = 0; po = 0; pd0 = 0; pd1 = 0; ps = 0; pi = 0;
    for (int t = 0; t <= 16384; t++) begin
      @(negedge clk);
      if (t > 0) begin
        chk("R11 valid", 128'(out_valid), 1);
        chk("R1 even", 128'(out_even), 128'(pe));
        chk("R2 odd", 128'(out_odd), 128'(po));
        chk("R3 dst", 128'({out_dst0, out_dst1}), 128'({pd0, pd1}));
        chk("R4 src", 128'(out_srcreg), 128'(ps));
        chk("R10 flag", 128'(out_invalid), 128'(pi));
      end
      if (t < 16384) begin
        logic [15:0] h0, h1, h2, h3;
        h0 = 16'(4 * t); h1 = h0 + 1; h2 = h0 + 2; h3 = h0 + 3;
        in_insn = word(5'(t % 32), 4'(t % 16));
        in_src = {h3, h2, h1, h0};
        in_valid = 1;
        pe = {ref_w(h2), ref_w(h0)};
        po = {ref_w(h3), ref_w(h1)};
        pd0 = 5'(2 * (t % 16)); pd1 = pd0 + 1; ps = 5'(t % 32);
        pi = ref_sn(h0) | ref_sn(h1) | ref_sn(h2) | ref_sn(h3);
      end else in_valid = 0;
    end

    one(word(5'd3, 4'd7), {16'h0400, 16'h7BFF, 16'hC000, 16'h3C00},
        {32'h477FE000, 32'h3F800000}, {32'h38800000, 32'hC0000000}, 0, "R7");
    one(word(5'd3, 4'd7), {16'h0000, 16'h03FF, 16'h8000, 16'h0001},
        {32'h387FC000, 32'h33800000}, {32'h00000000, 32'h80000000}, 0, "R8");
    one(word(5'd3, 4'd7), {16'h7E55, 16'h7E00, 16'hFC00, 16'h7C00},
        {32'h7FC00000, 32'h7F800000}, {32'h7FCAA000, 32'hFF800000}, 0, "R9");
    one(word(5'd3, 4'd7), {16'h0000, 16'h3C00, 16'hFD00, 16'h7C01},
        {32'h3F800000, 32'h7FC02000}, {32'h00000000, 32'hFFE00000}, 1, "R10");

    @(negedge clk);
    in_insn = word(5'd9, 4'd2); in_src = {16'h0, 16'h0, 16'h0, 16'h3C00};
    in_valid = 1; out_ready = 0;
    @(negedge clk);
    in_insn = word(5'd1, 4'd1); in_src = {4{16'h4000}};
    repeat (3) @(negedge clk);
    chk("R11 stall ready", 128'(in_ready), 0);
    chk("R11 hold data", 128'(out_even), 128'({32'h0, 32'h3F800000}));
    chk("R11 hold dst", 128'(out_dst0), 128'(4));
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R11 next data", 128'(out_even), 128'({2{32'h40000000}}));
    chk("R11 next dst", 128'(out_dst1), 128'(3));
    @(negedge clk);
    chk("R11 drained", 128'(out_valid), 0);

    feat_en = 0;
    @(negedge clk);
    in_insn = word(5'd4, 4'd4); in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R6 undef", 128'(out_undef), 1);
    chk("R6 no result", 128'(out_valid), 0);
    feat_en = 1;
    @(negedge clk);
    chk("R6 undef pulse", 128'(out_undef), 0);

    for (int b = 0; b < 23; b++) begin
      logic [31:0] w;
      w = word(5'd4, 4'd4);
      w[b == 0 ? 0 : b + 9] = ~w[b == 0 ? 0 : b + 9];
      @(negedge clk);
      in_insn = w; in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      chk("R5 undef", 128'(out_undef), 1);
      chk("R5 no result", 128'(out_valid), 0);
    end

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule